// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It takes 32-bit trace words from a valid/ready stream and stores them in an internal RAM that is used as a ring. Each accepted word goes to the location under the write pointer, and the write pointer then advances and wraps at the configured depth. A sticky full flag records that the ring has wrapped at least once. Once that has happened, the oldest word sits at the write pointer and not at location 0.

Software reaches the block through a word-addressed register port. Reading the RAM data register returns the word at the read pointer and moves the read pointer on. Writing the RAM data register stores a word at the write pointer and moves the write pointer on. Together these let software clear the RAM and dump the ring without any separate address register.

Capture can end in three ways. Software can clear the enable bit. A trigger input can arm a down-counter of further words to store, and capture stops when the counter runs out. A manual flush request can also end capture. When capture ends on a flush or on an expired trigger count, the block first pads the current 4-word frame with zero words, so the write pointer stops on a frame boundary.

Top module: `trc_buffer`

## Requirements
- R1: After reset, capture is off, `tr_ready` is low, both pointers are 0, the full flag is 0, the depth register (0x004) reads DEPTH and the flush status register (0x300) reads 2.
- R2: While control bit 0 (0x020) is 1 and no padding is in progress, `tr_ready` is high. Every word with `tr_valid` and `tr_ready` high at a clock edge is stored at the write pointer, and the write pointer then advances by one modulo DEPTH.
- R3: Status bit 0 (0x00C) is set by any RAM write that lands at location DEPTH-1. It stays set until software writes the write-pointer register (0x018).
- R4: A bus write to 0x024 while capture is off stores `bus_wdata` at the write pointer and advances the write pointer. While capture is on, such a write is ignored.
- R5: A bus read strobe at 0x010 returns the RAM word at the read pointer and advances the read pointer by one modulo DEPTH. Looking at 0x010 without the read strobe, or reading any other address, leaves the read pointer unchanged.
- R6: Bus writes to 0x014 and 0x018 load the read pointer and the write pointer. Both registers read back the current pointer value.
- R7: With flush-control bit 13 (0x304) set, a `trig_in` pulse during capture arms the trigger counter (0x01C). Each word accepted in a later cycle decrements the counter. When the counter reaches 0, `tr_ready` drops, zero words are written until the write pointer is a multiple of 4, and control bit 0 then clears.
- R8: Writing flush-control bit 6 as 1 starts a flush, and the bit reads back as 1 while the flush runs. During capture, zero words pad to the next 4-word boundary, bit 6 then clears, and capture stops if bit 12 is set or carries on if it is not. With capture off, the flush completes at the next edge.
- R9: Flush status bit 1 reads 1 exactly when capture is off and no flush is pending.
- R10: Writing control bit 0 as 0 stops capture at once: `tr_ready` is low from the next cycle and no padding words are written.
- R11: Flush-control bit 0 is stored and read back. It has no effect on what is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tr_valid | input | 1 | Trace word valid |
| tr_data | input | DW | Trace word |
| tr_ready | output | 1 | Block accepts a trace word this cycle |
| trig_in | input | 1 | Trigger event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the RAM read port) |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |

## Verification
A corrupted write pointer or a missed increment shows up on the next read of 0x018. It also shows up later as a dump in the wrong order, because every stored word lands one slot off. A wrong padding or trigger state is visible within a cycle as `tr_ready` going low too early or too late, and as a final write pointer that is not on a frame boundary. A lost full flag appears on the next status read after a wrap. The reference model tracks all of this state on every edge and compares `tr_ready` and the register read data in every cycle, so a divergence is flagged in the cycle it first reaches a port.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam logic [11:0] A_DEPTH  = 12'h004;
   localparam logic [11:0] A_STAT   = 12'h00C;
   localparam logic [11:0] A_RDAT   = 12'h010;
   localparam logic [11:0] A_RPTR   = 12'h014;
   localparam logic [11:0] A_WPTR   = 12'h018;
   localparam logic [11:0] A_TRG    = 12'h01C;
   localparam logic [11:0] A_CTRL   = 12'h020;
   localparam logic [11:0] A_WDAT   = 12'h024;
   localparam logic [11:0] A_FSTAT  = 12'h300;
   localparam logic [11:0] A_FCTRL  = 12'h304;

   localparam int FC_FMT    = 0;
   localparam int FC_FLUSH  = 6;
   localparam int FC_SFLUSH = 12;
   localparam int FC_STRIG  = 13;
   localparam int FS_STOP   = 1;
   localparam int FRAME_W   = 4;
endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
   parameter int DW    = 32,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/trc_wrap_ptr.sv
module trc_wrap_ptr #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] ptr_nx;

   // a power-of-two depth wraps on natural overflow, otherwise compare
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign ptr_nx = ptr + 1'b1;
      end else begin : g_cmp
         assign ptr_nx = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= ptr_nx;
   end
endmodule

// File: rtl/trc_seq.sv
module trc_seq #(
   parameter int TCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ctrl_we,
   input  logic           ctrl_en,
   input  logic           fc_we,
   input  logic           fc_fmt,
   input  logic           fc_flush,
   input  logic           fc_sflush,
   input  logic           fc_strig,
   input  logic           trg_we,
   input  logic [TCW-1:0] trg_val,
   input  logic           trig_in,
   input  logic           tr_valid,
   input  logic           wp_aligned,
   output logic           cap_en,
   output logic           tr_ready,
   output logic           accept,
   output logic           padding,
   output logic           pad_wr,
   output logic           fmt_en,
   output logic           flush_busy,
   output logic           stop_flush,
   output logic           stop_trig,
   output logic [TCW-1:0] trg_cnt,
   output logic           stopped
);
   logic armed;
   logic trig_done;
   logic pad_done;

   assign trig_done = stop_trig & armed & (trg_cnt == '0);
   assign padding   = cap_en & (flush_busy | trig_done);
   assign tr_ready  = cap_en & ~padding;
   assign accept    = tr_valid & tr_ready;
   assign pad_wr    = padding & ~wp_aligned;
   assign pad_done  = padding & wp_aligned;
   assign stopped   = ~cap_en & ~flush_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en     <= 1'b0;
         armed      <= 1'b0;
         flush_busy <= 1'b0;
         fmt_en     <= 1'b0;
         stop_flush <= 1'b0;
         stop_trig  <= 1'b0;
         trg_cnt    <= '0;
      end else begin
         if (pad_done) begin
            flush_busy <= 1'b0;
            if (trig_done | stop_flush) cap_en <= 1'b0;
         end
         if (!cap_en && flush_busy) flush_busy <= 1'b0;

         if (trg_we)                           trg_cnt <= trg_val;
         else if (accept && armed && trg_cnt != '0) trg_cnt <= trg_cnt - 1'b1;

         if (ctrl_we) begin
            cap_en <= ctrl_en;
            armed  <= 1'b0;
         end else if (trig_in && tr_ready && stop_trig) begin
            armed <= 1'b1;
         end

         if (fc_we) begin
            fmt_en     <= fc_fmt;
            stop_flush <= fc_sflush;
            stop_trig  <= fc_strig;
            if (fc_flush) flush_busy <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/trc_buffer.sv
module trc_buffer #(
   parameter int DW    = 32,
   parameter int DEPTH = 64,
   parameter int TCW   = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tr_valid,
   input  logic [DW-1:0] tr_data,
   output logic          tr_ready,
   input  logic          trig_in,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [11:0]   bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata
);
   import trc_pkg::*;

   generate
      if (DEPTH < FRAME_W || (DEPTH % FRAME_W) != 0) begin : g_bad_depth
         $error("trc_buffer: DEPTH must be a multiple of the frame size");
      end
      if (DW > 32 || DW < 1) begin : g_bad_dw
         $error("trc_buffer: DW must be 1..32");
      end
      if (TCW > 32 || TCW < 1) begin : g_bad_tcw
         $error("trc_buffer: TCW must be 1..32");
      end
   endgenerate

   logic          cap_en, accept, padding, pad_wr;
   logic          fmt_en, flush_busy, stop_flush, stop_trig, stopped;
   logic [TCW-1:0] trg_cnt;
   logic [AW-1:0] wp, rp;
   logic [DW-1:0] ram_wdata, ram_rdata;
   logic          full;
   logic          host_wp_we, host_rp_we, host_ctrl_we, host_ram_we, host_pop;
   logic          ram_we;

   assign host_wp_we   = bus_wr && bus_addr == A_WPTR;
   assign host_rp_we   = bus_wr && bus_addr == A_RPTR;
   assign host_ctrl_we = bus_wr && bus_addr == A_CTRL;
   assign host_ram_we  = bus_wr && bus_addr == A_WDAT && !cap_en;
   assign host_pop     = bus_rd && bus_addr == A_RDAT;

   trc_seq #(.TCW(TCW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (host_ctrl_we),
      .ctrl_en    (bus_wdata[0]),
      .fc_we      (bus_wr && bus_addr == A_FCTRL),
      .fc_fmt     (bus_wdata[FC_FMT]),
      .fc_flush   (bus_wdata[FC_FLUSH]),
      .fc_sflush  (bus_wdata[FC_SFLUSH]),
      .fc_strig   (bus_wdata[FC_STRIG]),
      .trg_we     (bus_wr && bus_addr == A_TRG),
      .trg_val    (bus_wdata[TCW-1:0]),
      .trig_in    (trig_in),
      .tr_valid   (tr_valid),
      .wp_aligned (wp[1:0] == 2'b00),
      .cap_en     (cap_en),
      .tr_ready   (tr_ready),
      .accept     (accept),
      .padding    (padding),
      .pad_wr     (pad_wr),
      .fmt_en     (fmt_en),
      .flush_busy (flush_busy),
      .stop_flush (stop_flush),
      .stop_trig  (stop_trig),
      .trg_cnt    (trg_cnt),
      .stopped    (stopped)
   );

   assign ram_we    = accept | pad_wr | host_ram_we;
   assign ram_wdata = accept ? tr_data : (pad_wr ? '0 : bus_wdata[DW-1:0]);

   trc_wrap_ptr #(.DEPTH(DEPTH)) u_wp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (host_wp_we),
      .load_val (bus_wdata[AW-1:0]),
      .inc      (ram_we),
      .ptr      (wp)
   );

   trc_wrap_ptr #(.DEPTH(DEPTH)) u_rp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (host_rp_we),
      .load_val (bus_wdata[AW-1:0]),
      .inc      (host_pop),
      .ptr      (rp)
   );

   trc_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (wp),
      .wdata (ram_wdata),
      .raddr (rp),
      .rdata (ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               full <= 1'b0;
      else if (host_wp_we)                      full <= 1'b0;
      else if (ram_we && wp == AW'(DEPTH - 1))  full <= 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_DEPTH: bus_rdata = 32'(DEPTH);
         A_STAT:  bus_rdata[0] = full;
         A_RDAT:  bus_rdata[DW-1:0] = ram_rdata;
         A_RPTR:  bus_rdata[AW-1:0] = rp;
         A_WPTR:  bus_rdata[AW-1:0] = wp;
         A_TRG:   bus_rdata[TCW-1:0] = trg_cnt;
         A_CTRL:  bus_rdata[0] = cap_en;
         A_FSTAT: bus_rdata[FS_STOP] = stopped;
         A_FCTRL: begin
            bus_rdata[FC_FMT]    = fmt_en;
            bus_rdata[FC_FLUSH]  = flush_busy;
            bus_rdata[FC_SFLUSH] = stop_flush;
            bus_rdata[FC_STRIG]  = stop_trig;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/trc_buffer_chk.sv
module trc_buffer_chk #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tr_valid,
   input logic          tr_ready,
   input logic          cap_en,
   input logic          padding,
   input logic          full,
   input logic [AW-1:0] wp,
   input logic          host_wp_we,
   input logic          host_ctrl_we
);
   // R2
   ready_needs_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |-> !tr_ready);

   // R8
   no_accept_while_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      padding |-> !tr_ready);

   // R3
   full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && !host_wp_we |=> full);

   // R2
   wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tr_valid && tr_ready && !host_wp_we |=>
         wp == (($past(wp) == AW'(DEPTH - 1)) ? '0 : $past(wp) + 1'b1));

   // R7
   stop_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_en) && !$past(host_ctrl_we) |-> wp[1:0] == 2'b00);
endmodule

bind trc_buffer trc_buffer_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tr_valid     (tr_valid),
   .tr_ready     (tr_ready),
   .cap_en       (cap_en),
   .padding      (padding),
   .full         (full),
   .wp           (wp),
   .host_wp_we   (host_wp_we),
   .host_ctrl_we (host_ctrl_we)
);

// File: tb/tb_trc_buffer.sv
module tb_trc_buffer;
   localparam int CLK_P = 10;
   localparam int D     = 16;
   localparam int TW    = 8;

   localparam logic [11:0] DEP = 12'h004, STA = 12'h00C, RDA = 12'h010,
      RPT = 12'h014, WPT = 12'h018, TRG = 12'h01C, CTL = 12'h020,
      WDA = 12'h024, FST = 12'h300, FCT = 12'h304;

   logic clk = 0, rst_n = 0;
   logic tr_valid = 0, trig_in = 0, bus_wr = 0, bus_rd = 0;
   logic [31:0] tr_data = 0, bus_wdata = 0;
   logic [11:0] bus_addr = 0;
   logic tr_ready;
   logic [31:0] bus_rdata;

   int n_chk = 0, n_bad = 0;

   trc_buffer #(.DW(32), .DEPTH(D), .TCW(TW)) dut (
      .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_data(tr_data),
      .tr_ready(tr_ready), .trig_in(trig_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   always #(CLK_P/2) clk = ~clk;

   // reference model state
   logic [31:0] m_mem [D];
   int m_wp, m_rp, m_cnt;
   bit m_full, m_cap, m_fb, m_fmt, m_sf, m_st, m_arm;

   function automatic bit m_tstop();
      return m_st && m_arm && m_cnt == 0;
   endfunction
   function automatic bit m_ready();
      return m_cap && !m_fb && !m_tstop();
   endfunction
   function automatic logic [31:0] m_rdata(input logic [11:0] a);
      case (a)
         DEP: return D;
         STA: return {31'b0, m_full};
         RDA: return m_mem[m_rp];
         RPT: return m_rp;
         WPT: return m_wp;
         TRG: return m_cnt;
         CTL: return {31'b0, m_cap};
         FST: return (!m_cap && !m_fb) ? 32'd2 : 32'd0;
         FCT: return (32'(m_st) << 13) | (32'(m_sf) << 12) | (32'(m_fb) << 6) | 32'(m_fmt);
         default: return 0;
      endcase
   endfunction

   task automatic m_store(input logic [31:0] v);
      m_mem[m_wp] = v;
      if (m_wp == D-1) m_full = 1;
      m_wp = (m_wp + 1) % D;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wp = 0; m_rp = 0; m_cnt = 0; m_full = 0; m_cap = 0; m_fb = 0;
         m_fmt = 0; m_sf = 0; m_st = 0; m_arm = 0;
      end else begin
         bit o_cap, o_rdy, o_ts, o_pad, acc;
         o_cap = m_cap; o_rdy = m_ready(); o_ts = m_tstop();
         o_pad = m_cap && (m_fb || o_ts);
         acc = tr_valid && o_rdy;
         if (acc) begin
            if (m_arm && m_cnt != 0) m_cnt--;
            m_store(tr_data);
         end
         if (o_pad) begin
            if (m_wp % 4 != 0) m_store(0);
            else begin
               m_fb = 0;
               if (o_ts || m_sf) m_cap = 0;
            end
         end
         if (!o_cap && m_fb) m_fb = 0;
         if (trig_in && o_rdy && m_st) m_arm = 1;
         if (bus_rd && bus_addr == RDA) m_rp = (m_rp + 1) % D;
         if (bus_wr) case (bus_addr)
            WDA: if (!o_cap) m_store(bus_wdata);
            RPT: m_rp = bus_wdata % D;
            WPT: begin m_wp = bus_wdata % D; m_full = 0; end
            TRG: m_cnt = bus_wdata % (1 << TW);
            CTL: begin m_cap = bus_wdata[0]; m_arm = 0; end
            FCT: begin
               m_fmt = bus_wdata[0]; m_sf = bus_wdata[12]; m_st = bus_wdata[13];
               if (bus_wdata[6]) m_fb = 1;
            end
            default: ;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle against the model
   always @(negedge clk) if (rst_n) begin
      chk("R2 model tr_ready", {31'b0, tr_ready}, {31'b0, m_ready()});
      chk("R5 model bus_rdata", bus_rdata, m_rdata(bus_addr));
   end

   task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1; bus_wr = w; bus_rd = 0; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1; bus_wr = 0; bus_rd = 0;
   endtask
   task automatic peek(input logic [11:0] a, output logic [31:0] v);
      @(posedge clk); #1; bus_addr = a; bus_wr = 0; bus_rd = 0;
      @(negedge clk); v = bus_rdata;
   endtask
   task automatic pop(output logic [31:0] v);
      @(posedge clk); #1; bus_addr = RDA; bus_rd = 1;
      @(negedge clk); v = bus_rdata;
      @(posedge clk); #1; bus_rd = 0;
   endtask
   task automatic run(input int n, input int gap, input int trig_at);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         tr_valid = (gap == 0) || (i % gap != 0);
         tr_data  = 32'hA000 + i;
         trig_in  = (i == trig_at);
      end
      @(posedge clk); #1; tr_valid = 0; trig_in = 0;
   endtask
   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      peek(DEP, v); chk("R1 depth", v, D);
      peek(STA, v); chk("R1 status", v, 0);
      peek(WPT, v); chk("R1 wp", v, 0);
      peek(RPT, v); chk("R1 rp", v, 0);
      peek(FST, v); chk("R1 R9 flush status", v, 2);
      chk("R1 tr_ready", {31'b0, tr_ready}, 0);
      // R4 host fill and R3 full flag
      bus(1, WPT, 0);
      for (int i = 0; i < D; i++) bus(1, WDA, 32'h100 + i);
      peek(WPT, v); chk("R4 wp after fill", v, 0);
      peek(STA, v); chk("R3 full after wrap", v, 1);
      bus(1, WPT, 0);
      peek(STA, v); chk("R3 full cleared", v, 0);
      // R6 pointer load, R5 pop
      bus(1, RPT, 3);
      peek(RPT, v); chk("R6 rp load", v, 3);
      peek(RDA, v); chk("R5 peek data", v, 32'h103);
      peek(RPT, v); chk("R5 peek no move", v, 3);
      for (int i = 0; i < D; i++) begin
         pop(v); chk("R5 dump", v, 32'h100 + ((3 + i) % D));
      end
      peek(RPT, v); chk("R5 rp wrapped", v, 3);
      // R11
      bus(1, FCT, 1);
      peek(FCT, v); chk("R11 fmt readback", v, 1);
      // R2 capture, R4 ignored write
      bus(1, CTL, 1);
      chk("R2 ready on", {31'b0, tr_ready}, 1);
      bus(1, WDA, 32'hDEAD);
      peek(WPT, v); chk("R4 write ignored", v, 0);
      run(6, 0, -1);
      peek(WPT, v); chk("R2 wp after 6", v, 6);
      bus(1, RPT, 0);
      for (int i = 0; i < 6; i++) begin
         pop(v); chk("R2 stored word", v, 32'hA000 + i);
      end
      // R8 flush without stop
      bus(1, FCT, 32'h41);
      idle(4);
      peek(WPT, v); chk("R8 pad to 8", v, 8);
      peek(FCT, v); chk("R8 flush bit cleared", v, 1);
      peek(CTL, v); chk("R8 capture continues", v, 1);
      // R8 flush with stop
      run(5, 3, -1);
      peek(WPT, v); chk("R2 gapped stream", v, 11);
      bus(1, FCT, 32'h1041);
      idle(4);
      peek(WPT, v); chk("R8 pad to 12", v, 12);
      peek(CTL, v); chk("R8 stopped", v, 0);
      peek(FST, v); chk("R9 stopped status", v, 2);
      peek(FCT, v); chk("R8 fc readback", v, 32'h1001);
      // R7 trigger, aligned stop
      bus(1, WPT, 0);
      bus(1, TRG, 5);
      bus(1, FCT, 32'h2001);
      bus(1, CTL, 1);
      run(20, 0, 2);
      peek(CTL, v); chk("R7 stop after count", v, 0);
      peek(WPT, v); chk("R7 wp aligned 8", v, 8);
      peek(TRG, v); chk("R7 counter expired", v, 0);
      // R7 trigger, padded stop
      bus(1, WPT, 0);
      bus(1, TRG, 2);
      bus(1, CTL, 1);
      run(20, 0, 0);
      peek(WPT, v); chk("R7 padded to 4", v, 4);
      peek(CTL, v); chk("R7 stopped", v, 0);
      bus(1, RPT, 3);
      pop(v); chk("R7 pad word zero", v, 0);
      // R3 wrap by capture, R10 immediate stop
      bus(1, FCT, 1);
      bus(1, WPT, 0);
      bus(1, CTL, 1);
      run(20, 0, -1);
      peek(STA, v); chk("R3 full by capture", v, 1);
      fork
         run(10, 0, -1);
         begin repeat (3) @(posedge clk); bus(1, CTL, 0); end
      join
      chk("R10 ready low", {31'b0, tr_ready}, 0);
      peek(WPT, v); chk("R10 no padding", v, m_wp);
      // R8 flush while off
      bus(1, FCT, 32'h41);
      peek(FCT, v); chk("R8 flush off completes", v, 1);
      peek(FST, v); chk("R9 idle", v, 2);
      // final dump
      bus(1, RPT, 0);
      for (int i = 0; i < D; i++) begin
         pop(v); chk("R5 final dump", v, m_mem[i]);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule